// File: doc/BRIEF.md
# CPU/DMA Bandwidth Account Arbiter

This block decides, burst by burst, whether a memory controller serves a CPU request port or a DMA request port. The CPU's share of bandwidth is limited by a credit account: serving the CPU charges the account, idle or DMA time drains it, and while the account is nonzero the CPU gives way to pending DMA traffic. DMA requests carry a real-time tag, and a control bit decides whether that tag is honoured or every DMA request is treated as urgent.

Two accounting schemes are offered. In per-burst mode the account is charged once, at the end of each CPU burst, by the programmed ratio plus the burst length. In per-cycle mode it is charged by the ratio on every cycle of CPU service, and it does not drain on those cycles. A further control bit chooses whether the account keeps draining while a DMA window is open or holds its value.

A grant lasts for the whole burst, whose length is sampled when the grant is issued; arbitration happens only at burst boundaries, including the last cycle of a burst, so bursts may run back to back.

Top module: `bwarb_top`

## Requirements
- R1: While reset is asserted (active low) and on the first cycle after it, both grants are 0 and the account reads 0.
- R2: With dyn_mode = 0, on the last cycle of a CPU burst the account gains ratio plus the burst length sampled at grant; the ordinary one-per-cycle drain still applies on that cycle (from 0, ratio 5 and length 4 give 8).
- R3: With dyn_mode = 1, the account gains ratio on every cycle that cpu_gnt is 1 and never drains on such a cycle.
- R4: On every other cycle the account drains by one, and it never goes below zero.
- R5: With win_decr = 0 and dma_window = 1, the account holds its value on cycles without CPU charge; with win_decr = 1 it drains during the window as usual.
- R6: A hard real-time DMA request beats the CPU whatever the account; with rt_class_en = 0 every DMA request is hard, so dma_soft = 1 is ignored.
- R7: With rt_class_en = 1 and dma_soft = 1 (soft request), the CPU wins only if the account is zero; otherwise DMA wins.
- R8: A CPU request with no DMA request pending is granted whatever the account.
- R9: A grant lasts exactly the burst length sampled when it was issued (a length of 0 counts as 1); a request arriving mid-burst waits, and at the burst's last cycle the next winner is chosen so its grant follows without a gap.
- R10: The account saturates at 65535 instead of wrapping.
- R11: cpu_gnt and dma_gnt are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU burst request |
| dma_req | input | 1 | DMA burst request |
| dma_soft | input | 1 | 1 marks the DMA request soft real-time |
| dma_window | input | 1 | DMA window currently open |
| burst_len | input | 8 | Burst length in cycles, sampled at grant |
| ratio | input | 10 | Account charge ratio |
| dyn_mode | input | 1 | 0: charge per burst, 1: charge per service cycle |
| win_decr | input | 1 | 1: drain during DMA window, 0: hold |
| rt_class_en | input | 1 | 1: honour dma_soft, 0: all DMA is hard |
| cpu_gnt | output | 1 | CPU owns the current burst |
| dma_gnt | output | 1 | DMA owns the current burst |
| account | output | 16 | Current CPU account value |

## Verification
The bench aims at the places where the two accounting modes part ways: a per-burst charge that skipped the drain on the final cycle would read one high, and a per-cycle mode that still drained during service would read four low after a four-cycle burst. It asserts a hard DMA request mid-way through a CPU burst while shrinking the length input, so a design that preempts, re-samples the length, or leaves an idle gap at the boundary shows the wrong grant count. Soft requests are tried both with an empty and a charged account, and the tag is set under a disabled real-time class to catch a design that honours it anyway. The window hold, the zero floor, the zero-length burst and the saturation ceiling are each driven to their edge.

// File: rtl/bwarb_pkg.sv
package bwarb_pkg;
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_CPU  = 2'd1,
        OWN_DMA  = 2'd2
    } owner_e;
endpackage

// File: rtl/bwarb_pick.sv
module bwarb_pick
    import bwarb_pkg::*;
(
    input  logic   cpu_req,
    input  logic   dma_req,
    input  logic   dma_soft,
    input  logic   rt_class_en,
    input  logic   acc_zero,
    output owner_e winner
);
    logic dma_hard;

    always_comb begin
        dma_hard = dma_req && !(rt_class_en && dma_soft);
        if (cpu_req && !dma_req) begin
            winner = OWN_CPU;
        end else if (cpu_req && !dma_hard && acc_zero) begin
            winner = OWN_CPU;
        end else if (dma_req) begin
            winner = OWN_DMA;
        end else begin
            winner = OWN_NONE;
        end
    end
endmodule

// File: rtl/bwarb_acct.sv
module bwarb_acct #(
    parameter int ACCW = 16,
    parameter int RATW = 10,
    parameter int LENW = 8
) (
    input  logic [ACCW-1:0] acc_q,
    input  logic [RATW-1:0] ratio,
    input  logic [LENW-1:0] len_q,
    input  logic            dyn_mode,
    input  logic            win_decr,
    input  logic            dma_window,
    input  logic            cpu_svc,
    input  logic            cpu_last,
    output logic [ACCW-1:0] acc_d
);
    localparam int SW = ACCW + 2;
    localparam logic [SW-1:0] ACC_MAX = {2'b00, {ACCW{1'b1}}};

    logic [SW-1:0] inc;
    logic [SW-1:0] sum;
    logic          drain;

    always_comb begin
        inc = '0;
        if (dyn_mode) begin
            if (cpu_svc) inc = SW'(ratio);
        end else if (cpu_last) begin
            inc = SW'(ratio) + SW'(len_q);
        end
        drain = !(dyn_mode && cpu_svc) && !(!win_decr && dma_window);
        sum = SW'(acc_q) + inc;
        if (drain && sum != '0) sum = sum - SW'(1);
        if (sum > ACC_MAX) sum = ACC_MAX;
        acc_d = sum[ACCW-1:0];
    end
endmodule

// File: rtl/bwarb_top.sv
module bwarb_top
    import bwarb_pkg::*;
#(
    parameter int ACCW = 16,
    parameter int RATW = 10,
    parameter int LENW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_req,
    input  logic            dma_req,
    input  logic            dma_soft,
    input  logic            dma_window,
    input  logic [LENW-1:0] burst_len,
    input  logic [RATW-1:0] ratio,
    input  logic            dyn_mode,
    input  logic            win_decr,
    input  logic            rt_class_en,
    output logic            cpu_gnt,
    output logic            dma_gnt,
    output logic [ACCW-1:0] account
);
    typedef struct packed {
        owner_e          owner;
        logic [LENW-1:0] rem;
        logic [LENW-1:0] len;
        logic [ACCW-1:0] acc;
    } state_t;

    state_t          st_q, st_d;
    owner_e          winner;
    logic [ACCW-1:0] acc_next;
    logic [LENW-1:0] eff_len;
    logic            boundary;
    logic            cpu_svc;
    logic            cpu_last;
    logic [LENW-1:0] rem_cur;

    assign cpu_svc  = (st_q.owner == OWN_CPU);
    assign cpu_last = cpu_svc && (st_q.rem == '0);
    assign boundary = (st_q.owner == OWN_NONE) || (st_q.rem == '0);
    assign eff_len  = (burst_len == '0) ? LENW'(1) : burst_len;
    assign rem_cur  = st_q.rem;

    bwarb_pick u_pick (
        .cpu_req     (cpu_req),
        .dma_req     (dma_req),
        .dma_soft    (dma_soft),
        .rt_class_en (rt_class_en),
        .acc_zero    (st_q.acc == '0),
        .winner      (winner)
    );

    bwarb_acct #(.ACCW(ACCW), .RATW(RATW), .LENW(LENW)) u_acct (
        .acc_q      (st_q.acc),
        .ratio      (ratio),
        .len_q      (st_q.len),
        .dyn_mode   (dyn_mode),
        .win_decr   (win_decr),
        .dma_window (dma_window),
        .cpu_svc    (cpu_svc),
        .cpu_last   (cpu_last),
        .acc_d      (acc_next)
    );

    always_comb begin
        st_d     = st_q;
        st_d.acc = acc_next;
        if (boundary) begin
            st_d.owner = winner;
            if (winner != OWN_NONE) begin
                st_d.len = eff_len;
                st_d.rem = eff_len - LENW'(1);
            end else begin
                st_d.rem = '0;
            end
        end else begin
            st_d.rem = st_q.rem - LENW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{owner: OWN_NONE, rem: '0, len: '0, acc: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_gnt = (st_q.owner == OWN_CPU);
    assign dma_gnt = (st_q.owner == OWN_DMA);
    assign account = st_q.acc;
endmodule

// File: rtl/bwarb_chk.sv
module bwarb_chk #(
    parameter int ACCW = 16,
    parameter int LENW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cpu_gnt,
    input logic            dma_gnt,
    input logic [ACCW-1:0] account,
    input logic            dyn_mode,
    input logic            win_decr,
    input logic            dma_window,
    input logic [LENW-1:0] burst_rem
);
    // R11
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_gnt && dma_gnt));

    // R4
    charge_needs_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (account > $past(account)) |-> $past(cpu_gnt));

    // R3
    dyn_no_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cpu_gnt && dyn_mode) |-> (account >= $past(account)));

    // R5
    window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!win_decr && dma_window && !cpu_gnt) |-> (account == $past(account)));

    // R9
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past((cpu_gnt || dma_gnt) && burst_rem != '0) |-> ($stable(cpu_gnt) && $stable(dma_gnt)));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!cpu_gnt && !dma_gnt && account == '0));
endmodule

bind bwarb_top bwarb_chk #(.ACCW(ACCW), .LENW(LENW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_gnt    (cpu_gnt),
    .dma_gnt    (dma_gnt),
    .account    (account),
    .dyn_mode   (dyn_mode),
    .win_decr   (win_decr),
    .dma_window (dma_window),
    .burst_rem  (rem_cur)
);

// File: tb/tb_bwarb_top.sv
`timescale 1ns/1ps
module tb_bwarb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, dma_req = 1'b0, dma_soft = 1'b0, dma_window = 1'b0;
    logic [7:0]  burst_len = 8'd4;
    logic [9:0]  ratio = 10'd0;
    logic        dyn_mode = 1'b0, win_decr = 1'b1, rt_class_en = 1'b0;
    logic        cpu_gnt, dma_gnt;
    logic [15:0] account;
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    bwarb_top dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .dma_req(dma_req),
        .dma_soft(dma_soft), .dma_window(dma_window), .burst_len(burst_len),
        .ratio(ratio), .dyn_mode(dyn_mode), .win_decr(win_decr),
        .rt_class_en(rt_class_en), .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt),
        .account(account)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000 && (cpu_gnt || dma_gnt); i++) @(negedge clk);
    endtask

    task automatic drain();
        win_decr = 1'b1; dma_window = 1'b0;
        for (int i = 0; i < 70000 && account != 16'd0; i++) @(negedge clk);
    endtask

    // Issue one CPU burst from idle; returns grant cycles, ends at first idle negedge.
    task automatic cpu_burst(input int len, output int cnt);
        burst_len = 8'(len);
        cpu_req = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0;
        cnt = 0;
        for (int i = 0; i < 300 && cpu_gnt; i++) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R1 cpu_gnt", cpu_gnt, 0);
        chk("R1 dma_gnt", dma_gnt, 0);
        chk("R1 account", account, 0);
    endtask

    task automatic t_static();
        int n;
        drain(); dyn_mode = 1'b0; ratio = 10'd5;
        cpu_burst(4, n);
        chk("R9 static len", n, 4);
        chk("R2 static charge", account, 8);
        @(negedge clk);
        chk("R4 drain", account, 7);
    endtask

    task automatic t_floor();
        drain();
        repeat (3) @(negedge clk);
        chk("R4 floor zero", account, 0);
    endtask

    task automatic t_dynamic_window();
        int n;
        drain(); dyn_mode = 1'b1; ratio = 10'd3;
        cpu_burst(4, n);
        chk("R3 dyn charge", account, 12);
        @(negedge clk);
        chk("R4 drain after dyn", account, 11);
        win_decr = 1'b0; dma_window = 1'b1;
        repeat (5) @(negedge clk);
        chk("R5 window hold", account, 11);
        win_decr = 1'b1;
        @(negedge clk);
        chk("R5 window drain", account, 10);
        dma_window = 1'b0; dyn_mode = 1'b0;
    endtask

    task automatic t_hard_tag_ignored();
        drain(); rt_class_en = 1'b0; dma_soft = 1'b1; burst_len = 8'd3;
        cpu_req = 1'b1; dma_req = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0; dma_req = 1'b0;
        chk("R6 dma wins tag ignored", dma_gnt, 1);
        chk("R6 cpu loses", cpu_gnt, 0);
        wait_idle(); dma_soft = 1'b0;
    endtask

    task automatic t_soft_zero();
        drain(); rt_class_en = 1'b1; dma_soft = 1'b1; burst_len = 8'd2;
        cpu_req = 1'b1; dma_req = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0; dma_req = 1'b0;
        chk("R7 cpu wins soft at zero", cpu_gnt, 1);
        wait_idle();
    endtask

    task automatic t_soft_charged();
        int n;
        drain(); dyn_mode = 1'b0; ratio = 10'd20;
        cpu_burst(2, n);
        chk("R2 charge before soft", account, 21);
        rt_class_en = 1'b1; dma_soft = 1'b1; burst_len = 8'd2;
        cpu_req = 1'b1; dma_req = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0; dma_req = 1'b0;
        chk("R7 soft dma wins charged", dma_gnt, 1);
        wait_idle();
        chk("R8 account nonzero", int'(account != 0), 1);
        cpu_req = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0;
        chk("R8 lone cpu granted", cpu_gnt, 1);
        wait_idle(); dma_soft = 1'b0; rt_class_en = 1'b0;
    endtask

    task automatic t_hold_b2b();
        int n = 0;
        int m = 0;
        drain(); ratio = 10'd1; burst_len = 8'd6;
        cpu_req = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0; dma_req = 1'b1; burst_len = 8'd2;
        for (int i = 0; i < 50 && cpu_gnt; i++) begin
            n++;
            chk("R11 exclusive", int'(cpu_gnt && dma_gnt), 0);
            @(negedge clk);
        end
        dma_req = 1'b0;
        chk("R9 cpu held full burst", n, 6);
        chk("R9 dma follows without gap", dma_gnt, 1);
        for (int i = 0; i < 50 && dma_gnt; i++) begin
            m++;
            @(negedge clk);
        end
        chk("R9 dma length sampled", m, 2);
        drain();
        cpu_burst(0, n);
        chk("R9 zero length is one", n, 1);
    endtask

    task automatic t_saturate();
        int n;
        dyn_mode = 1'b1; ratio = 10'd1023;
        cpu_burst(100, n);
        chk("R10 saturate", account, 65535);
        @(negedge clk);
        chk("R10 drain from max", account, 65534);
    endtask

    initial begin
        #4000000;
        fails++;
        checks++;
        $display("FAIL R0 watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_static();
        t_floor();
        t_dynamic_window();
        t_hard_tag_ignored();
        t_soft_zero();
        t_soft_charged();
        t_hold_b2b();
        t_saturate();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule